// File: doc/BRIEF.md
# SPI Transmit Command/Data Queue

This block is the transmit-side queue of an SPI master controller. Each write to the push port stores one entry, made of a command word and a data word that stay together. The shift engine takes the oldest entry through a pop handshake when it starts a transfer. The queue holds four entries by default.

The block reports four things: how many entries are waiting, which slot the next transfer will use, a fill-request flag and a sticky underflow flag. The fill-request flag goes to either an interrupt line or a DMA request line, chosen by a select input. A flush input empties the queue. A disable input turns the queue into a single-entry buffer, and the status outputs then behave as for a queue of depth one.

The shift engine watches `pop_valid` and asserts `pop_req` when it wants an entry. In the cycle where both are high, it takes `pop_cmd` and `pop_data`.

Top module: `spi_txq`

## Requirements
- R1: After reset, `entry_count` is 0, `next_ptr` is 0, `fill_flag` is 1, `underflow` is 0 and `pop_valid` is 0.
- R2: Entries leave in the order they were pushed, and each entry's command and data come out together.
- R3: In the cycle after an accepted push, `entry_count` is one higher. In the cycle after a pop, it is one lower. When an accepted push and a pop happen in the same cycle, it does not change.
- R4: A push made while `entry_count` equals the capacity is dropped. The count and `next_ptr` do not change, and the stored entries are not altered.
- R5: `next_ptr` is the slot offset from slot 0 of the entry that the next pop will return. It goes up by one after each pop and wraps modulo the depth.
- R6: If `entry_count` is below the capacity in a cycle, `fill_flag` is 1 in the next cycle.
- R7: While the queue is full, `fill_flag` clears in the next cycle when either `dma_push_done` or `fill_w1c` is 1. Otherwise it keeps its value.
- R8: `underflow` is set in the cycle after `pop_req` is high while `entry_count` is 0 and `flush` is 0. It stays set until `unf_w1c` is pulsed. When a set and a clear arrive in the same cycle, the set wins.
- R9: A flush makes `entry_count` and `next_ptr` 0 in the next cycle. A push or pop in the flush cycle is ignored, and `fill_flag` is 1 in the cycle after that.
- R10: When `req_sel_dma` is 0, `irq_req` follows `fill_flag` and `dma_req` is 0. When `req_sel_dma` is 1, the roles swap.
- R11: With `fifo_disable` at 1, the capacity is one. `entry_count` stays at 0 or 1, a second push is dropped, `fill_flag` follows R6 and R7 with a capacity of one, and `next_ptr` reads 0.
- R12: `pop_valid` is 1 exactly when `entry_count` is nonzero and `flush` is 0. While it is 1, `pop_cmd` and `pop_data` show the entry at `next_ptr`. A pop takes place when `pop_req` and `pop_valid` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| push_valid | input | 1 | Write strobe of the push port |
| push_cmd | input | CMD_W | Command word of the pushed entry |
| push_data | input | DATA_W | Data word of the pushed entry |
| dma_push_done | input | 1 | The DMA engine signals that its push write has completed |
| fill_w1c | input | 1 | Software writes 1 to clear the fill flag |
| unf_w1c | input | 1 | Software writes 1 to clear the underflow flag |
| flush | input | 1 | Empties the queue |
| fifo_disable | input | 1 | Single-entry buffer mode |
| req_sel_dma | input | 1 | Routes the fill flag: 0 to the interrupt line, 1 to the DMA line |
| pop_req | input | 1 | The shift engine requests an entry |
| pop_valid | output | 1 | An entry is available to pop |
| pop_cmd | output | CMD_W | Command word of the entry at the head |
| pop_data | output | DATA_W | Data word of the entry at the head |
| entry_count | output | CNT_W | Number of valid entries |
| next_ptr | output | PTR_W | Slot offset of the next entry to pop |
| fill_flag | output | 1 | Fill-request status |
| underflow | output | 1 | Sticky underflow status |
| irq_req | output | 1 | Interrupt request from the fill flag |
| dma_req | output | 1 | DMA request from the fill flag |

## Verification
The assertions assume that `fifo_disable` only changes while the queue is empty. The stimulus therefore switches the mode only right after a flush has drained the queue. All inputs are assumed to be synchronous to `clk`, and the bench drives them on the falling edge. Pushes, pops, flushes and flag clears are drawn at random, including pushes into a full queue and pops from an empty one. Directed steps then force the full-queue, flag-clear, flush and single-entry cases.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;

  typedef enum logic {
    ROUTE_IRQ = 1'b0,
    ROUTE_DMA = 1'b1
  } route_e;

  // slot index following p in a ring of depth slots
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/spi_txq_rst_sync.sv
module spi_txq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/spi_txq_store.sv
module spi_txq_store #(
  parameter int DEPTH = 4,
  parameter int ENT_W = 32,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [ENT_W-1:0] rd_ent
);

  logic [ENT_W-1:0] slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic             slot_en;
    logic [ENT_W-1:0] slot_q;

    assign slot_en = wr_en && (wr_ptr == PTR_W'(g));

    // payload storage: clock enable only, no reset needed
    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= wr_ent;
    end

    assign slots[g] = slot_q;
  end

  assign rd_ent = slots[rd_ptr];

endmodule

// File: rtl/spi_txq_ctrl.sv
module spi_txq_ctrl
  import spi_txq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic             pop_req,
  input  logic             flush,
  input  logic             fifo_disable,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cap;
  logic             state_en;

  assign cap     = fifo_disable ? CNT_W'(1) : CNT_W'(DEPTH);
  assign full    = (cnt_q == cap);
  assign empty   = (cnt_q == '0);
  assign push_ok = push_valid && !flush && (cnt_q < cap);
  assign pop_ok  = pop_req && !flush && !empty;
  assign state_en = flush || push_ok || pop_ok;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok)
        wr_ptr_d = fifo_disable ? '0 : PTR_W'(ring_next(32'(wr_ptr_q), DEPTH));
      if (pop_ok)
        rd_ptr_d = fifo_disable ? '0 : PTR_W'(ring_next(32'(rd_ptr_q), DEPTH));
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (state_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign wr_ptr = wr_ptr_q;
  assign rd_ptr = rd_ptr_q;
  assign count  = cnt_q;

endmodule

// File: rtl/spi_txq_flags.sv
module spi_txq_flags
  import spi_txq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic full,
  input  logic empty,
  input  logic pop_req,
  input  logic flush,
  input  logic dma_push_done,
  input  logic fill_w1c,
  input  logic unf_w1c,
  input  logic req_sel_dma,
  output logic fill_flag,
  output logic underflow,
  output logic irq_req,
  output logic dma_req
);

  logic   fill_q, fill_d;
  logic   unf_q, unf_d;
  logic   unf_set;
  route_e route;

  assign unf_set = pop_req && empty && !flush;
  assign route   = route_e'(req_sel_dma);

  always_comb begin
    fill_d = fill_q;
    if (!full)                          fill_d = 1'b1;
    else if (dma_push_done || fill_w1c) fill_d = 1'b0;

    unf_d = unf_q;
    if (unf_set)      unf_d = 1'b1;
    else if (unf_w1c) unf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= 1'b1;
      unf_q  <= 1'b0;
    end else begin
      fill_q <= fill_d;
      unf_q  <= unf_d;
    end
  end

  assign fill_flag = fill_q;
  assign underflow = unf_q;
  assign irq_req   = fill_q && (route == ROUTE_IRQ);
  assign dma_req   = fill_q && (route == ROUTE_DMA);

endmodule

// File: rtl/spi_txq.sv
module spi_txq #(
  parameter int DEPTH  = 4,
  parameter int CMD_W  = 16,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int ENT_W = CMD_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [CMD_W-1:0]  push_cmd,
  input  logic [DATA_W-1:0] push_data,
  input  logic              dma_push_done,
  input  logic              fill_w1c,
  input  logic              unf_w1c,
  input  logic              flush,
  input  logic              fifo_disable,
  input  logic              req_sel_dma,
  input  logic              pop_req,
  output logic              pop_valid,
  output logic [CMD_W-1:0]  pop_cmd,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W-1:0]  entry_count,
  output logic [PTR_W-1:0]  next_ptr,
  output logic              fill_flag,
  output logic              underflow,
  output logic              irq_req,
  output logic              dma_req
);

  logic             rst_sync_n;
  logic             push_ok, pop_ok, q_full, q_empty;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [ENT_W-1:0] rd_ent;

  spi_txq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  spi_txq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .push_valid   (push_valid),
    .pop_req      (pop_req),
    .flush        (flush),
    .fifo_disable (fifo_disable),
    .push_ok      (push_ok),
    .pop_ok       (pop_ok),
    .wr_ptr       (wr_ptr),
    .rd_ptr       (rd_ptr),
    .count        (entry_count),
    .full         (q_full),
    .empty        (q_empty)
  );

  spi_txq_store #(.DEPTH(DEPTH), .ENT_W(ENT_W), .PTR_W(PTR_W)) u_store (
    .clk    (clk),
    .wr_en  (push_ok),
    .wr_ptr (wr_ptr),
    .wr_ent ({push_cmd, push_data}),
    .rd_ptr (rd_ptr),
    .rd_ent (rd_ent)
  );

  spi_txq_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .full          (q_full),
    .empty         (q_empty),
    .pop_req       (pop_req),
    .flush         (flush),
    .dma_push_done (dma_push_done),
    .fill_w1c      (fill_w1c),
    .unf_w1c       (unf_w1c),
    .req_sel_dma   (req_sel_dma),
    .fill_flag     (fill_flag),
    .underflow     (underflow),
    .irq_req       (irq_req),
    .dma_req       (dma_req)
  );

  assign pop_valid = !q_empty && !flush;
  assign {pop_cmd, pop_data} = rd_ent;
  assign next_ptr  = rd_ptr;

endmodule

// File: rtl/spi_txq_chk.sv
module spi_txq_chk
  import spi_txq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             push_valid,
  input logic             pop_req,
  input logic             flush,
  input logic             fifo_disable,
  input logic             dma_push_done,
  input logic             fill_w1c,
  input logic             req_sel_dma,
  input logic             pop_valid,
  input logic [CNT_W-1:0] entry_count,
  input logic [PTR_W-1:0] next_ptr,
  input logic             fill_flag,
  input logic             underflow,
  input logic             irq_req,
  input logic             dma_req
);

  logic [CNT_W-1:0] cap;
  logic [PTR_W-1:0] ptr_after;
  assign cap       = fifo_disable ? CNT_W'(1) : CNT_W'(DEPTH);
  assign ptr_after = PTR_W'(ring_next(32'(next_ptr), DEPTH));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_ok)
    entry_count <= CNT_W'(DEPTH));

  a_r3_push_inc: assert property (@(posedge clk) disable iff (!rst_ok)
    push_valid && !pop_req && !flush && !fifo_disable && (entry_count < CNT_W'(DEPTH))
    |=> entry_count == $past(entry_count) + CNT_W'(1));

  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_ok)
    push_valid && !pop_req && !flush && (entry_count == cap)
    |=> (entry_count == $past(entry_count)) && $stable(next_ptr));

  a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_ok)
    pop_valid && pop_req && !fifo_disable |=> next_ptr == $past(ptr_after));

  a_r6_fill_set: assert property (@(posedge clk) disable iff (!rst_ok)
    (entry_count != cap) |=> fill_flag);

  a_r7_fill_clear: assert property (@(posedge clk) disable iff (!rst_ok)
    (entry_count == cap) && !flush && !pop_req && (dma_push_done || fill_w1c) |=> !fill_flag);

  a_r8_underflow_set: assert property (@(posedge clk) disable iff (!rst_ok)
    pop_req && (entry_count == '0) && !flush |=> underflow);

  a_r9_flush_clear: assert property (@(posedge clk) disable iff (!rst_ok)
    flush |=> (entry_count == '0) && (next_ptr == '0));

  a_r9_flush_fill: assert property (@(posedge clk) disable iff (!rst_ok)
    flush |-> ##2 fill_flag);

  a_r10_route_onehot: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({irq_req, dma_req}) && (fill_flag == (irq_req || dma_req)));

  a_r10_route_sel: assert property (@(posedge clk) disable iff (!rst_ok)
    req_sel_dma |-> !irq_req);

  a_r11_single: assert property (@(posedge clk) disable iff (!rst_ok)
    fifo_disable |-> (entry_count <= CNT_W'(1)) && (next_ptr == '0));

  a_r12_valid: assert property (@(posedge clk) disable iff (!rst_ok)
    pop_valid |-> (entry_count != '0) && !flush);

endmodule

bind spi_txq spi_txq_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_ok        (rst_sync_n),
  .push_valid    (push_valid),
  .pop_req       (pop_req),
  .flush         (flush),
  .fifo_disable  (fifo_disable),
  .dma_push_done (dma_push_done),
  .fill_w1c      (fill_w1c),
  .req_sel_dma   (req_sel_dma),
  .pop_valid     (pop_valid),
  .entry_count   (entry_count),
  .next_ptr      (next_ptr),
  .fill_flag     (fill_flag),
  .underflow     (underflow),
  .irq_req       (irq_req),
  .dma_req       (dma_req)
);

// File: tb/spi_txq_tb.sv
`timescale 1ns/1ps
module spi_txq_tb;

  logic        clk;
  logic        rst_n;
  logic        push_valid, dma_push_done, fill_w1c, unf_w1c, flush;
  logic        fifo_disable, req_sel_dma, pop_req;
  logic [15:0] push_cmd, push_data;
  logic        pop_valid, fill_flag, underflow, irq_req, dma_req;
  logic [15:0] pop_cmd, pop_data;
  logic [2:0]  entry_count;
  logic [1:0]  next_ptr;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int          m_cnt, m_ptr;
  logic        m_fill, m_unf;
  logic [31:0] m_mem [4];

  spi_txq u_dut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_cmd(push_cmd), .push_data(push_data),
    .dma_push_done(dma_push_done), .fill_w1c(fill_w1c), .unf_w1c(unf_w1c),
    .flush(flush), .fifo_disable(fifo_disable), .req_sel_dma(req_sel_dma),
    .pop_req(pop_req), .pop_valid(pop_valid), .pop_cmd(pop_cmd), .pop_data(pop_data),
    .entry_count(entry_count), .next_ptr(next_ptr), .fill_flag(fill_flag),
    .underflow(underflow), .irq_req(irq_req), .dma_req(dma_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int cap_of(input logic dis);
    return dis ? 1 : 4;
  endfunction

  function automatic int tail_of(input int ptr, input int cnt, input logic dis);
    return dis ? 0 : (ptr + cnt) % 4;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string pick(input string dflt, input string tag);
    return (tag == "") ? dflt : tag;
  endfunction

  // one clock cycle: drive on the falling edge, check, then advance the model on the rising edge
  task automatic step(input logic pv, input logic [15:0] pc, input logic [15:0] pd,
                      input logic pr, input logic fl, input logic dd, input logic fw,
                      input logic uw, input logic dis, input logic sel, input string tag);
    logic pok, rok, fill_n, unf_n;
    int   cap;
    @(negedge clk);
    push_valid = pv; push_cmd = pc; push_data = pd; pop_req = pr; flush = fl;
    dma_push_done = dd; fill_w1c = fw; unf_w1c = uw; fifo_disable = dis; req_sel_dma = sel;
    #1;
    chk(pick("R3", tag), "entry_count", 32'(entry_count), 32'(m_cnt));
    chk(pick("R5", tag), "next_ptr", 32'(next_ptr), 32'(m_ptr));
    chk(pick("R6", tag), "fill_flag", 32'(fill_flag), 32'(m_fill));
    chk(pick("R8", tag), "underflow", 32'(underflow), 32'(m_unf));
    chk(pick("R10", tag), "irq_req", 32'(irq_req), 32'(m_fill && !sel));
    chk(pick("R10", tag), "dma_req", 32'(dma_req), 32'(m_fill && sel));
    chk(pick("R12", tag), "pop_valid", 32'(pop_valid), 32'((m_cnt != 0) && !fl));
    if ((m_cnt != 0) && !fl)
      chk(pick("R2", tag), "pop entry", {pop_cmd, pop_data}, m_mem[m_ptr]);
    @(posedge clk);
    cap    = cap_of(dis);
    pok    = pv && !fl && (m_cnt < cap);
    rok    = pr && !fl && (m_cnt != 0);
    fill_n = (m_cnt != cap) ? 1'b1 : ((dd || fw) ? 1'b0 : m_fill);
    unf_n  = (pr && !fl && (m_cnt == 0)) ? 1'b1 : (uw ? 1'b0 : m_unf);
    if (fl) begin
      m_cnt = 0;
      m_ptr = 0;
    end else begin
      if (pok) m_mem[tail_of(m_ptr, m_cnt, dis)] = {pc, pd};
      if (rok) m_ptr = dis ? 0 : (m_ptr + 1) % 4;
      m_cnt = m_cnt + (pok ? 1 : 0) - (rok ? 1 : 0);
    end
    m_fill = fill_n;
    m_unf  = unf_n;
  endtask

  task automatic idle(input logic dis, input string tag);
    step(1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, dis, 1'b0, tag);
  endtask

  task automatic push(input logic [15:0] c, input logic [15:0] d, input logic dis, input string tag);
    step(1'b1, c, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, dis, 1'b0, tag);
  endtask

  task automatic pop(input logic dis, input string tag);
    step(1'b0, 16'h0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, dis, 1'b0, tag);
  endtask

  task automatic do_flush(input logic dis, input string tag);
    step(1'b1, 16'hdead, 16'hbeef, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, dis, 1'b0, tag);
  endtask

  task automatic rand_phase(input int n, input logic dis);
    logic sel = 1'b0;
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(0, 31) == 0) sel = ~sel;
      step($urandom_range(0, 99) < 50, 16'($urandom), 16'($urandom),
           $urandom_range(0, 99) < 40, $urandom_range(0, 99) < 3,
           $urandom_range(0, 99) < 10, $urandom_range(0, 99) < 5,
           $urandom_range(0, 99) < 10, dis, sel, "");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_cnt = 0; m_ptr = 0; m_fill = 1'b1; m_unf = 1'b0;
    for (int i = 0; i < 4; i++) m_mem[i] = '0;
    push_valid = 0; push_cmd = 0; push_data = 0; pop_req = 0; flush = 0;
    dma_push_done = 0; fill_w1c = 0; unf_w1c = 0; fifo_disable = 0; req_sel_dma = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle(1'b0, "R1");

    // R4 R2: fill to four, push a fifth, drain in order
    for (int i = 0; i < 5; i++) push(16'(16'h100 + i), 16'(16'h200 + i), 1'b0, "R4");
    idle(1'b0, "R7");
    idle(1'b0, "R7");
    // R7: software clear while full, then DMA clear after refill
    step(1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
    idle(1'b0, "R7");
    for (int i = 0; i < 4; i++) pop(1'b0, "R2");
    // R8: pop from empty, then clear
    pop(1'b0, "R8");
    idle(1'b0, "R8");
    step(1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    idle(1'b0, "R8");
    // R3: push and pop in the same cycle keeps the count
    push(16'h0a0a, 16'h0b0b, 1'b0, "R3");
    step(1'b1, 16'h0c0c, 16'h0d0d, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    idle(1'b0, "R3");
    for (int i = 0; i < 3; i++) push(16'(i), 16'(i + 7), 1'b0, "R9");
    step(1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    do_flush(1'b0, "R9");
    idle(1'b0, "R9");
    idle(1'b0, "R9");

    rand_phase(3000, 1'b0);

    // R11: switch to single-entry mode only with an empty queue
    do_flush(1'b0, "R9");
    idle(1'b0, "R11");
    push(16'h1111, 16'h2222, 1'b1, "R11");
    push(16'h3333, 16'h4444, 1'b1, "R11");
    idle(1'b1, "R11");
    step(1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R11");
    pop(1'b1, "R11");
    idle(1'b1, "R11");
    rand_phase(2000, 1'b1);

    do_flush(1'b1, "R9");
    idle(1'b0, "R9");
    rand_phase(1000, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule